// File: doc/BRIEF.md
# Warm-reset and boot-state control register

This block is a 64-bit control register that belongs to the highest privilege level of a core. Software writes it to ask for a warm reset and to choose whether the core restarts in its 32-bit or its 64-bit execution state. The block decodes system-register access encodings and applies the privilege rules. An access from the level below, when nested virtualisation is turned on, is sent to a trap with a fixed syndrome. Any other access that is not allowed is reported as an undefined instruction.

On the reset side, the block raises a one-cycle warm-reset request towards a simple reset sequencer. The sequencer answers with a "warm reset applied" strobe. On that strobe the block clears its pending request and latches the boot-state output from the stored selection. The boot selection is set only by the cold reset, which is the asynchronous reset of this block. It survives every warm reset, so the state chosen before the reset is the one the core boots into.

Top module: `rst_boot_ctl`

## Requirements
- R1: Bits 63 down to 2 of the register always read as 0, and write data in those bits has no effect on any later read.
- R2: Bit 1 is the pending warm-reset request. An accepted write with bit 1 = 1 sets it. A write with bit 1 = 0 does not clear it. The cold reset clears it, and a read returns its current value in bit 1.
- R3: `warm_req_o` is high for exactly one cycle, in the cycle after an accepted write that sets bit 1. This happens only if no request was already pending, or if the pending request is being cleared in that same cycle. Otherwise no pulse is produced.
- R4: A cycle with `warm_done_i` = 1 clears the pending request (bit 1 reads 0 afterwards), unless an accepted write sets bit 1 in that same cycle.
- R5: Bit 0 is the boot-state selection: 0 means the 32-bit state and 1 means the 64-bit state. The cold reset sets it to 1. `warm_done_i` does not change it, and only an accepted write does.
- R6: `boot_aa64_o` is 1 after cold reset. It takes the stored bit 0 in the cycle after `warm_done_i` = 1, using the value held before any write made in that same cycle. It is unchanged in every other cycle.
- R7: With parameter `AA32_OK` = 0, bit 0 reads as 1, writes to it are ignored, and `boot_aa64_o` stays 1.
- R8: Only the encoding op0=2'b11, op1=3'b100, CRn=4'b1100, CRm=4'b0000, op2=3'b010 selects the register. A request with any other encoding produces no response and changes no state.
- R9: A matching access made at level 1 (`acc_el_i` = 1) while `acc_el2_on_i` = 1 and `acc_nv_i` = 1 sets `rsp_trap_o` with `rsp_syndrome_o` = 6'h18 and read data 0. It changes no register state and raises no request.
- R10: A matching access made at level 2 (`acc_el_i` = 2) while `acc_el2_on_i` = 1 and parameter `EL2_IS_TOP` = 1 is performed and sets `rsp_ok_o`. A read returns the register value, while a write response carries read data 0.
- R11: Every other matching access sets `rsp_undef_o` and changes no state. This covers level 0, level 3, level 1 without the trap condition, level 2 with `acc_el2_on_i` = 0, and level 2 when `EL2_IS_TOP` = 0.
- R12: A response appears in the cycle after the request. In a response cycle exactly one of `rsp_ok_o`, `rsp_trap_o` and `rsp_undef_o` is 1, and outside one all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| acc_valid_i | input | 1 | System-register access request present |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_op0_i | input | 2 | Encoding field op0 |
| acc_op1_i | input | 3 | Encoding field op1 |
| acc_crn_i | input | 4 | Encoding field CRn |
| acc_crm_i | input | 4 | Encoding field CRm |
| acc_op2_i | input | 3 | Encoding field op2 |
| acc_el_i | input | 2 | Privilege level of the access |
| acc_el2_on_i | input | 1 | Level 2 enabled in the current security state |
| acc_nv_i | input | 1 | Nested-virtualisation control bit |
| acc_wdata_i | input | 64 | Write data |
| warm_done_i | input | 1 | Sequencer strobe: warm reset is being applied |
| rsp_valid_o | output | 1 | Response present |
| rsp_ok_o | output | 1 | Access performed |
| rsp_trap_o | output | 1 | Access trapped to level 2 |
| rsp_undef_o | output | 1 | Undefined-instruction outcome |
| rsp_syndrome_o | output | 6 | Trap syndrome code |
| rsp_rdata_o | output | 64 | Read data |
| warm_req_o | output | 1 | One-cycle warm-reset request |
| boot_aa64_o | output | 1 | Boot state for the warm reset: 1 = 64-bit |

## Verification
The hardest situation to reach is a single cycle in which the sequencer's applied strobe coincides with a software write. Two things must hold in that cycle. The latched boot state must come from the value held before the write. A fresh request must still pulse even though the old request is still stored. The stimulus reaches this by leaving a request pending on purpose, and then driving the strobe and a write in the same cycle. It is followed by reads that show what was kept. A second and third instance, one without 32-bit support and one where level 2 is not the top level, receive the same accesses, so that the parameter variants are compared within one run.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    localparam int REG_W    = 64;
    localparam int SYN_W    = 6;
    localparam int RR_BIT   = 1;
    localparam int BOOT_BIT = 0;
    localparam int LVL_W    = 2;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam sysenc_t CTL_ENC = '{op0: 2'b11, op1: 3'b100, crn: 4'b1100,
                                    crm: 4'b0000, op2: 3'b010};

    localparam logic [SYN_W-1:0] TRAP_SYN = 6'h18;
    localparam logic [LVL_W-1:0] LVL_GUEST = 2'd1;
    localparam logic [LVL_W-1:0] LVL_HYP   = 2'd2;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_DO,
        KIND_TRAP,
        KIND_UNDEF
    } acc_kind_e;

endpackage

// File: rtl/rbc_access_chk.sv
module rbc_access_chk
    import rbc_pkg::*;
#(
    parameter bit EL2_IS_TOP = 1'b1
) (
    input  logic             valid_i,
    input  sysenc_t          enc_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             el2_on_i,
    input  logic             nv_i,
    output acc_kind_e        kind_o
);

    logic hit;
    assign hit = valid_i && (enc_i == CTL_ENC);

    always_comb begin
        if (!hit) begin
            kind_o = KIND_NONE;
        end else if (lvl_i == LVL_GUEST && el2_on_i && nv_i) begin
            kind_o = KIND_TRAP;
        end else if (lvl_i == LVL_HYP && EL2_IS_TOP && el2_on_i) begin
            kind_o = KIND_DO;
        end else begin
            kind_o = KIND_UNDEF;
        end
    end

endmodule

// File: rtl/rbc_fields.sv
module rbc_fields
    import rbc_pkg::*;
#(
    parameter bit AA32_OK = 1'b1
) (
    input  logic clk,
    input  logic cold_rst_n,
    input  logic wr_en_i,
    input  logic wd_rr_i,
    input  logic wd_boot_i,
    input  logic warm_done_i,
    output logic rr_o,
    output logic boot_view_o,
    output logic warm_req_o,
    output logic boot_aa64_o
);

    typedef struct packed {
        logic aa64;
        logic rr;
        logic req;
        logic boot;
    } fld_t;

    localparam fld_t FLD_COLD = '{aa64: 1'b1, rr: 1'b0, req: 1'b0, boot: 1'b1};

    fld_t fld_d, fld_q;
    logic set_req;
    logic boot_view;

    assign boot_view = AA32_OK ? fld_q.aa64 : 1'b1;
    assign set_req   = wr_en_i && wd_rr_i;

    always_comb begin
        fld_d     = fld_q;
        fld_d.rr  = (fld_q.rr && !warm_done_i) || set_req;
        fld_d.req = set_req && (!fld_q.rr || warm_done_i);
        if (warm_done_i) begin
            fld_d.boot = boot_view;
        end
        if (wr_en_i) begin
            fld_d.aa64 = AA32_OK ? wd_boot_i : 1'b1;
        end
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            fld_q <= FLD_COLD;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign rr_o        = fld_q.rr;
    assign boot_view_o = boot_view;
    assign warm_req_o  = fld_q.req;
    assign boot_aa64_o = fld_q.boot;

    // R3: a visible pulse always has its request stored
    assert_req_pending_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        warm_req_o |-> rr_o);

    // R3: without a clearing strobe the pulse lasts one cycle
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (warm_req_o && !warm_done_i) |=> !warm_req_o);

    // R4: the applied strobe clears the request unless re-set
    assert_req_clear_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (warm_done_i && !set_req) |=> !rr_o);

    // R6: boot output moves only on the applied strobe
    assert_boot_hold_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_done_i |=> $stable(boot_aa64_o));

    // R11: selection bit changes only through a performed write
    assert_sel_untouched_R11: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !wr_en_i |=> $stable(boot_view_o));

endmodule

// File: rtl/rbc_resp.sv
module rbc_resp
    import rbc_pkg::*;
(
    input  logic             clk,
    input  logic             cold_rst_n,
    input  acc_kind_e        kind_i,
    input  logic             write_i,
    input  logic [REG_W-1:0] reg_val_i,
    output logic             valid_o,
    output logic             ok_o,
    output logic             trap_o,
    output logic             undef_o,
    output logic [SYN_W-1:0] syn_o,
    output logic [REG_W-1:0] rdata_o
);

    typedef struct packed {
        logic             valid;
        logic             ok;
        logic             trap;
        logic             undef;
        logic [SYN_W-1:0] syn;
        logic [REG_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = (kind_i != KIND_NONE);
        rsp_d.ok    = (kind_i == KIND_DO);
        rsp_d.trap  = (kind_i == KIND_TRAP);
        rsp_d.undef = (kind_i == KIND_UNDEF);
        if (kind_i == KIND_TRAP) begin
            rsp_d.syn = TRAP_SYN;
        end
        if (kind_i == KIND_DO && !write_i) begin
            rsp_d.rdata = reg_val_i;
        end
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign valid_o = rsp_q.valid;
    assign ok_o    = rsp_q.ok;
    assign trap_o  = rsp_q.trap;
    assign undef_o = rsp_q.undef;
    assign syn_o   = rsp_q.syn;
    assign rdata_o = rsp_q.rdata;

    // R12: exactly one outcome per response, none otherwise
    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!cold_rst_n)
        valid_o |-> ($countones({ok_o, trap_o, undef_o}) == 1));
    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !valid_o |-> !(ok_o || trap_o || undef_o));

    // R1: reserved bits never show up
    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!cold_rst_n)
        rdata_o[REG_W-1:2] == '0);

    // R9: trap carries its fixed code and no data
    assert_trap_code_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        trap_o |-> (syn_o == TRAP_SYN && rdata_o == '0));

endmodule

// File: rtl/rst_boot_ctl.sv
module rst_boot_ctl
    import rbc_pkg::*;
#(
    parameter bit EL2_IS_TOP = 1'b1,
    parameter bit AA32_OK    = 1'b1
) (
    input  logic        clk,
    input  logic        cold_rst_n,
    input  logic        acc_valid_i,
    input  logic        acc_write_i,
    input  logic [1:0]  acc_op0_i,
    input  logic [2:0]  acc_op1_i,
    input  logic [3:0]  acc_crn_i,
    input  logic [3:0]  acc_crm_i,
    input  logic [2:0]  acc_op2_i,
    input  logic [1:0]  acc_el_i,
    input  logic        acc_el2_on_i,
    input  logic        acc_nv_i,
    input  logic [63:0] acc_wdata_i,
    input  logic        warm_done_i,
    output logic        rsp_valid_o,
    output logic        rsp_ok_o,
    output logic        rsp_trap_o,
    output logic        rsp_undef_o,
    output logic [5:0]  rsp_syndrome_o,
    output logic [63:0] rsp_rdata_o,
    output logic        warm_req_o,
    output logic        boot_aa64_o
);

    sysenc_t          enc;
    acc_kind_e        kind;
    logic             wr_en;
    logic             rr_cur;
    logic             boot_view;
    logic [REG_W-1:0] reg_val;
    logic             unused_wdata_rsv;

    assign enc = '{op0: acc_op0_i, op1: acc_op1_i, crn: acc_crn_i,
                   crm: acc_crm_i, op2: acc_op2_i};
    assign unused_wdata_rsv = ^acc_wdata_i[REG_W-1:2];

    rbc_access_chk #(.EL2_IS_TOP(EL2_IS_TOP)) u_chk (
        .valid_i  (acc_valid_i),
        .enc_i    (enc),
        .lvl_i    (acc_el_i),
        .el2_on_i (acc_el2_on_i),
        .nv_i     (acc_nv_i),
        .kind_o   (kind)
    );

    assign wr_en = (kind == KIND_DO) && acc_write_i;

    rbc_fields #(.AA32_OK(AA32_OK)) u_fields (
        .clk         (clk),
        .cold_rst_n  (cold_rst_n),
        .wr_en_i     (wr_en),
        .wd_rr_i     (acc_wdata_i[RR_BIT]),
        .wd_boot_i   (acc_wdata_i[BOOT_BIT]),
        .warm_done_i (warm_done_i),
        .rr_o        (rr_cur),
        .boot_view_o (boot_view),
        .warm_req_o  (warm_req_o),
        .boot_aa64_o (boot_aa64_o)
    );

    always_comb begin
        reg_val           = '0;
        reg_val[RR_BIT]   = rr_cur;
        reg_val[BOOT_BIT] = boot_view;
    end

    rbc_resp u_resp (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .kind_i     (kind),
        .write_i    (acc_write_i),
        .reg_val_i  (reg_val),
        .valid_o    (rsp_valid_o),
        .ok_o       (rsp_ok_o),
        .trap_o     (rsp_trap_o),
        .undef_o    (rsp_undef_o),
        .syn_o      (rsp_syndrome_o),
        .rdata_o    (rsp_rdata_o)
    );

    // R9: a trapped access never starts a reset request
    assert_trap_no_req_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (kind == KIND_TRAP && !warm_done_i) |=> $stable(rr_cur));

    generate
        if (!AA32_OK) begin : g_aa64_only
            // R7: fixed 64-bit selection in reads and boot output
            assert_fixed_sel_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
                ((rsp_ok_o && rsp_rdata_o != '0) |-> rsp_rdata_o[BOOT_BIT]) && boot_aa64_o);
        end
    endgenerate

endmodule

// File: tb/rst_boot_ctl_tb_top.sv
`timescale 1ns/1ps
module rst_boot_ctl_tb_top;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  op0 = '0;
    logic [2:0]  op1 = '0;
    logic [3:0]  crn = '0, crm = '0;
    logic [2:0]  op2 = '0;
    logic [1:0]  lvl = '0;
    logic        el2_on = 1'b0, nv = 1'b0;
    logic [63:0] wdata = '0;
    logic        warm_done = 1'b0;

    logic        v_m, ok_m, tr_m, un_m, req_m, boot_m;
    logic [5:0]  syn_m;
    logic [63:0] rd_m;
    logic        v_r, ok_r, tr_r, un_r, req_r, boot_r;
    logic [5:0]  syn_r;
    logic [63:0] rd_r;
    logic        v_h, ok_h, tr_h, un_h, req_h, boot_h;
    logic [5:0]  syn_h;
    logic [63:0] rd_h;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rst_boot_ctl dut_i (
        .clk(clk), .cold_rst_n(cold_rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_op0_i(op0), .acc_op1_i(op1), .acc_crn_i(crn), .acc_crm_i(crm), .acc_op2_i(op2),
        .acc_el_i(lvl), .acc_el2_on_i(el2_on), .acc_nv_i(nv), .acc_wdata_i(wdata),
        .warm_done_i(warm_done), .rsp_valid_o(v_m), .rsp_ok_o(ok_m), .rsp_trap_o(tr_m),
        .rsp_undef_o(un_m), .rsp_syndrome_o(syn_m), .rsp_rdata_o(rd_m),
        .warm_req_o(req_m), .boot_aa64_o(boot_m));

    rst_boot_ctl #(.AA32_OK(1'b0)) dut_ro_i (
        .clk(clk), .cold_rst_n(cold_rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_op0_i(op0), .acc_op1_i(op1), .acc_crn_i(crn), .acc_crm_i(crm), .acc_op2_i(op2),
        .acc_el_i(lvl), .acc_el2_on_i(el2_on), .acc_nv_i(nv), .acc_wdata_i(wdata),
        .warm_done_i(warm_done), .rsp_valid_o(v_r), .rsp_ok_o(ok_r), .rsp_trap_o(tr_r),
        .rsp_undef_o(un_r), .rsp_syndrome_o(syn_r), .rsp_rdata_o(rd_r),
        .warm_req_o(req_r), .boot_aa64_o(boot_r));

    rst_boot_ctl #(.EL2_IS_TOP(1'b0)) dut_nohi_i (
        .clk(clk), .cold_rst_n(cold_rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_op0_i(op0), .acc_op1_i(op1), .acc_crn_i(crn), .acc_crm_i(crm), .acc_op2_i(op2),
        .acc_el_i(lvl), .acc_el2_on_i(el2_on), .acc_nv_i(nv), .acc_wdata_i(wdata),
        .warm_done_i(warm_done), .rsp_valid_o(v_h), .rsp_ok_o(ok_h), .rsp_trap_o(tr_h),
        .rsp_undef_o(un_h), .rsp_syndrome_o(syn_h), .rsp_rdata_o(rd_h),
        .warm_req_o(req_h), .boot_aa64_o(boot_h));

    typedef struct packed {
        logic       wr;
        logic       enc;
        logic [1:0] el;
        logic       en;
        logic       nv;
        logic [1:0] wd;
        logic       ev;
        logic       eok;
        logic       etrap;
        logic       eundef;
        logic [1:0] erd;
        logic       ereq;
    } vec_t;

    localparam int NVEC = 17;
    // wr enc el en nv wd | valid ok trap undef rdata req
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b1,2'd2,1'b1,1'b0,2'b00, 1'b1,1'b1,1'b0,1'b0,2'b01,1'b0},
        '{1'b1,1'b1,2'd2,1'b1,1'b0,2'b00, 1'b1,1'b1,1'b0,1'b0,2'b00,1'b0},
        '{1'b0,1'b1,2'd2,1'b1,1'b0,2'b00, 1'b1,1'b1,1'b0,1'b0,2'b00,1'b0},
        '{1'b1,1'b1,2'd1,1'b1,1'b1,2'b11, 1'b1,1'b0,1'b1,1'b0,2'b00,1'b0},
        '{1'b0,1'b1,2'd2,1'b1,1'b0,2'b00, 1'b1,1'b1,1'b0,1'b0,2'b00,1'b0},
        '{1'b1,1'b1,2'd1,1'b1,1'b0,2'b11, 1'b1,1'b0,1'b0,1'b1,2'b00,1'b0},
        '{1'b1,1'b1,2'd0,1'b1,1'b1,2'b11, 1'b1,1'b0,1'b0,1'b1,2'b00,1'b0},
        '{1'b1,1'b1,2'd2,1'b0,1'b0,2'b11, 1'b1,1'b0,1'b0,1'b1,2'b00,1'b0},
        '{1'b1,1'b0,2'd2,1'b1,1'b0,2'b11, 1'b0,1'b0,1'b0,1'b0,2'b00,1'b0},
        '{1'b0,1'b1,2'd2,1'b1,1'b0,2'b00, 1'b1,1'b1,1'b0,1'b0,2'b00,1'b0},
        '{1'b0,1'b1,2'd1,1'b0,1'b1,2'b00, 1'b1,1'b0,1'b0,1'b1,2'b00,1'b0},
        '{1'b1,1'b1,2'd3,1'b1,1'b0,2'b11, 1'b1,1'b0,1'b0,1'b1,2'b00,1'b0},
        '{1'b1,1'b1,2'd2,1'b1,1'b0,2'b10, 1'b1,1'b1,1'b0,1'b0,2'b00,1'b1},
        '{1'b0,1'b1,2'd2,1'b1,1'b0,2'b00, 1'b1,1'b1,1'b0,1'b0,2'b10,1'b0},
        '{1'b1,1'b1,2'd2,1'b1,1'b0,2'b11, 1'b1,1'b1,1'b0,1'b0,2'b00,1'b0},
        '{1'b1,1'b1,2'd2,1'b1,1'b0,2'b01, 1'b1,1'b1,1'b0,1'b0,2'b00,1'b0},
        '{1'b0,1'b1,2'd2,1'b1,1'b0,2'b00, 1'b1,1'b1,1'b0,1'b0,2'b11,1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; outputs are sampled after the following edge.
    task automatic step(input logic vld, input logic wr, input logic encok, input logic [1:0] el,
                        input logic en, input logic nvb, input logic [1:0] wd, input logic done);
        acc_valid = vld;
        acc_write = wr;
        op0 = 2'b11; op1 = 3'b100; crn = 4'b1100; op2 = 3'b010;
        crm = encok ? 4'b0000 : 4'b0001;
        lvl = el; el2_on = en; nv = nvb;
        wdata = {{62{1'b1}}, wd};
        warm_done = done;
        @(negedge clk);
        acc_valid = 1'b0;
        warm_done = 1'b0;
    endtask

    task automatic rd_hyp();
        step(1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 2'b00, 1'b0);
    endtask

    task automatic wr_hyp(input logic [1:0] wd, input logic done);
        step(1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, wd, done);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R12 reset valid", {63'b0, v_m}, 64'd0);
        chk("R3 reset req", {63'b0, req_m}, 64'd0);
        chk("R6 reset boot", {63'b0, boot_m}, 64'd1);

        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, VECS[i].wr, VECS[i].enc, VECS[i].el, VECS[i].en, VECS[i].nv,
                 VECS[i].wd, 1'b0);
            chk($sformatf("R12/R8 vec%0d valid", i), {63'b0, v_m}, {63'b0, VECS[i].ev});
            chk($sformatf("R10 vec%0d ok", i), {63'b0, ok_m}, {63'b0, VECS[i].eok});
            chk($sformatf("R9 vec%0d trap", i), {63'b0, tr_m}, {63'b0, VECS[i].etrap});
            chk($sformatf("R11 vec%0d undef", i), {63'b0, un_m}, {63'b0, VECS[i].eundef});
            chk($sformatf("R9 vec%0d syndrome", i), {58'b0, syn_m},
                VECS[i].etrap ? 64'h18 : 64'h0);
            chk($sformatf("R1/R2/R5 vec%0d rdata", i), rd_m, {62'b0, VECS[i].erd});
            chk($sformatf("R3 vec%0d req", i), {63'b0, req_m}, {63'b0, VECS[i].ereq});
        end

        // R6: writes alone never move the boot output
        chk("R6 boot before apply", {63'b0, boot_m}, 64'd1);
        wr_hyp(2'b00, 1'b0);
        step(1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 2'b00, 1'b1);
        chk("R6 boot latched 0", {63'b0, boot_m}, 64'd0);
        chk("R3 no pulse on apply", {63'b0, req_m}, 64'd0);
        rd_hyp();
        chk("R4/R5 after apply", rd_m, 64'd0);

        // R6: write in the apply cycle is not seen by the boot output
        wr_hyp(2'b01, 1'b1);
        chk("R6 same-cycle write", {63'b0, boot_m}, 64'd0);
        rd_hyp();
        chk("R5 write kept", rd_m, 64'd1);

        // R3: new request while the old one is being cleared
        wr_hyp(2'b10, 1'b0);
        chk("R3 first pulse", {63'b0, req_m}, 64'd1);
        wr_hyp(2'b10, 1'b1);
        chk("R3 pulse during apply", {63'b0, req_m}, 64'd1);
        chk("R6 boot from stored 0", {63'b0, boot_m}, 64'd0);
        rd_hyp();
        chk("R4 re-set request kept", rd_m, 64'd2);
        step(1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 2'b00, 1'b1);
        rd_hyp();
        chk("R4 cleared", rd_m, 64'd0);

        // Cold reset restores the selection and clears the request
        cold_rst_n = 1'b0;
        @(negedge clk);
        cold_rst_n = 1'b1;
        @(negedge clk);
        chk("R6 cold boot", {63'b0, boot_m}, 64'd1);
        rd_hyp();
        chk("R5/R2 cold value", rd_m, 64'd1);

        // R7 and R10 parameter variants
        wr_hyp(2'b00, 1'b0);
        chk("R10 not-top write undef", {63'b0, un_h}, 64'd1);
        chk("R10 main write ok", {63'b0, ok_m}, 64'd1);
        rd_hyp();
        chk("R10 not-top read undef", {63'b0, un_h}, 64'd1);
        chk("R7 fixed selection read", rd_r, 64'd1);
        chk("R5 main selection read", rd_m, 64'd0);
        step(1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 2'b00, 1'b1);
        chk("R7 fixed boot", {63'b0, boot_r}, 64'd1);
        chk("R6 main boot", {63'b0, boot_m}, 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule